// File: doc/BRIEF.md
# Period-Match Timer With Buffered Byte Access

This block is a 16-bit up-counter driven by a count-enable strobe through a selectable prescaler. Software reaches it over an 8-bit register bus. The counter's upper byte cannot be read or written directly. It passes through a buffer register, so software can read or load all 16 bits as one consistent value even while the counter runs. A 16-bit period register sets where the count wraps back to zero. Reaching that value, or wrapping past FFFFh in continuous mode, raises a sticky interrupt flag.

There are two operating modes. In continuous mode the counter restarts from zero after each period hit and keeps running. In single-shot mode hardware turns the enable bit off at the period hit, so the timer stops after one full period.

Stimulus comes from a one-cycle strobe, `tick_i`, which a separate input conditioner produces. The bus uses single-cycle read and write strobes. Read data is combinational from the address.

Top module: `pm_timer`

## Requirements
- R1: After reset the counter, the high-byte buffer, the control byte and the flag are all 0, and the period is FFFFh. The register map is: address 0 control (bit0 enable, bit1 mode with 1 meaning single-shot, bits 3:2 prescale select), 1 counter low byte, 2 high-byte buffer, 3 period low, 4 period high, 5 flag (bit0).
- R2: A read of address 1 returns the live counter low byte and copies the live counter high byte into the buffer in the same cycle. A read of address 2 returns the buffer.
- R3: A write to address 2 changes only the buffer. A write to address 1 loads the counter with {buffer, written byte} and clears the prescaler.
- R4: A write to address 2 alone leaves the prescaler phase unchanged.
- R5: Prescale select values 0, 1, 2 and 3 make the counter advance once per 1, 2, 4 and 8 `tick_i` strobes. Strobes arriving while enable is 0 are ignored.
- R6: Clearing the enable bit keeps the count and resets the prescaler. Control writes never change the counter.
- R7: In continuous mode, a count event that finds the counter equal to the period, or equal to FFFFh, sets the counter to 0 and sets the flag. Counting then continues.
- R8: In single-shot mode, a count event that finds the counter equal to the period sets the counter to 0, sets the flag and clears the enable bit. A count event at FFFFh that is not a period match wraps to 0 without setting the flag.
- R9: The flag stays set until a write of 0 to bit0 of address 5. Writing 1 has no effect. A hardware set in the same cycle as a software clear leaves the flag set.
- R10: The period register may be written at any time, and the next period comparison uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count-enable strobe from the input conditioner |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt flag |

## Verification
A wrong prescaler phase makes the count arrive one or more strobes early or late. The sweep over every prescale setting, both modes and several periods then finds a counter value or flag that differs from the arithmetic expectation, on the first read after the strobe burst. A buffer that misses its capture, or commits too early, shows up as a torn 16-bit value on the next high-byte read. A wrong match or stop decision shows up on the flag or the enable bit within one count event.

// File: rtl/pm_timer_pkg.sv
// Shared register addresses and control-bit positions for the period-match timer.
package pm_timer_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_PER_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG   = 3'd5;

    localparam int B_EN   = 0;
    localparam int B_MODE = 1;
    localparam int B_PSL  = 2;

    typedef enum logic {MODE_CONT = 1'b0, MODE_ONESHOT = 1'b1} mode_e;
endpackage

// File: rtl/pm_prescaler.sv
// Prescaler: counts tick strobes while enabled and emits a count event on
// every 2**sel-th strobe. It assumes clr is high whenever the timer is
// disabled or the counter low byte is written.
module pm_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);
    localparam int PC_W = (1 << SEL_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] mask;

    // Low bits of pcnt that must all be 1 for an event.
    always_comb mask = ~({PC_W{1'b1}} << sel);

    // Event when the masked phase is full on an enabled strobe.
    always_comb evt = en && tick && !clr && ((pcnt & mask) == mask);

    // Phase counter, reset by clear, advanced by each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt <= '0;
        end else if (tick && en) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R4/R5: after a clear, a divided setting cannot fire on the first strobe.
    a_r5_no_early_event: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sel == '0 || !evt));
endmodule

// File: rtl/pm_count_core.sv
// Counter core: the 16-bit count, the high-byte buffer and the period
// comparison. It assumes wr_lo, wr_hi and rd_lo are single-cycle bus strobes
// and that evt comes from the prescaler.
module pm_count_core #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              oneshot,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [2*BYTE_W-1:0] period,
    output logic [2*BYTE_W-1:0] count,
    output logic [BYTE_W-1:0] shadow,
    output logic              hit_set
);
    localparam int CNT_W = 2 * BYTE_W;

    logic match;
    logic at_top;
    logic hit;

    // Period comparison and top-of-range detection.
    always_comb begin
        match  = (count == period);
        at_top = (count == {CNT_W{1'b1}});
        hit    = match || (at_top && !oneshot);
    end

    // A bus load of the counter takes priority over a count event.
    always_comb hit_set = evt && hit && !wr_lo;

    // Counter update: bus load, clear on hit, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count <= {shadow, wdata};
        end else if (evt) begin
            count <= hit ? '0 : count + 1'b1;
        end
    end

    // High-byte buffer: written by the bus, or captured on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_hi) begin
            shadow <= wdata;
        end else if (rd_lo) begin
            shadow <= count[CNT_W-1:BYTE_W];
        end
    end

    a_r2_capture_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !wr_hi) |=> shadow == $past(count[CNT_W-1:BYTE_W]));
    a_r3_hold_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !wr_lo) |=> $stable(count));
    a_r3_low_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[BYTE_W-1:0] == $past(wdata));
    a_r7_clear_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> count == '0);
endmodule

// File: rtl/pm_ctrl_regs.sv
// Control state: enable, mode, prescale select, period and the sticky flag.
// It assumes hit_set comes from the counter core in the same cycle as the
// count event that caused it.
module pm_ctrl_regs #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_per_lo,
    input  logic                wr_per_hi,
    input  logic                wr_flag,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                hit_set,
    output logic                en,
    output pm_timer_pkg::mode_e mode,
    output logic [SEL_W-1:0]    psel,
    output logic [2*BYTE_W-1:0] period,
    output logic                flag
);
    import pm_timer_pkg::*;

    logic stop;

    // Single-shot stop request.
    always_comb stop = hit_set && (mode == MODE_ONESHOT);

    // Control byte; the hardware stop overrides a write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            mode <= MODE_CONT;
            psel <= '0;
        end else begin
            if (wr_ctrl) begin
                en   <= wdata[B_EN];
                mode <= mode_e'(wdata[B_MODE]);
                psel <= wdata[B_PSL +: SEL_W];
            end
            if (stop) begin
                en <= 1'b0;
            end
        end
    end

    // Period bytes, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '1;
        end else begin
            if (wr_per_lo) period[BYTE_W-1:0]        <= wdata;
            if (wr_per_hi) period[2*BYTE_W-1:BYTE_W] <= wdata;
        end
    end

    // Sticky flag: a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit_set) begin
            flag <= 1'b1;
        end else if (wr_flag && !wdata[0]) begin
            flag <= 1'b0;
        end
    end

    a_r8_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !en);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> flag);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_flag && !wdata[0])) |=> flag);
endmodule

// File: rtl/pm_timer.sv
// Top level of the period-match timer. It decodes the byte bus, wires the
// prescaler, counter core and control registers together, and drives the
// combinational read mux. It assumes the bus strobes last one cycle.
module pm_timer #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_i,
    input  logic                           bus_wr_i,
    input  logic                           bus_rd_i,
    input  logic [pm_timer_pkg::ADDR_W-1:0] bus_addr_i,
    input  logic [BYTE_W-1:0]              bus_wdata_i,
    output logic [BYTE_W-1:0]              bus_rdata_o,
    output logic                           irq_o
);
    import pm_timer_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    logic wr_ctrl, wr_lo, wr_hi, wr_per_lo, wr_per_hi, wr_flag, rd_lo;
    logic en, evt, hit_set, flag, ps_clr;
    mode_e mode;
    logic [SEL_W-1:0] psel;
    logic [CNT_W-1:0] period, count;
    logic [BYTE_W-1:0] shadow;

    // Bus strobe decode.
    always_comb begin
        wr_ctrl   = bus_wr_i && (bus_addr_i == A_CTRL);
        wr_lo     = bus_wr_i && (bus_addr_i == A_CNT_LO);
        wr_hi     = bus_wr_i && (bus_addr_i == A_CNT_HI);
        wr_per_lo = bus_wr_i && (bus_addr_i == A_PER_LO);
        wr_per_hi = bus_wr_i && (bus_addr_i == A_PER_HI);
        wr_flag   = bus_wr_i && (bus_addr_i == A_FLAG);
        rd_lo     = bus_rd_i && (bus_addr_i == A_CNT_LO);
        ps_clr    = wr_lo || !en;
    end

    pm_prescaler #(.SEL_W(SEL_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(ps_clr),
        .tick(tick_i), .sel(psel), .evt(evt)
    );

    pm_count_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .oneshot(mode == MODE_ONESHOT),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .wdata(bus_wdata_i),
        .period(period), .count(count), .shadow(shadow), .hit_set(hit_set)
    );

    pm_ctrl_regs #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_per_lo(wr_per_lo),
        .wr_per_hi(wr_per_hi), .wr_flag(wr_flag), .wdata(bus_wdata_i),
        .hit_set(hit_set), .en(en), .mode(mode), .psel(psel),
        .period(period), .flag(flag)
    );

    // Read mux over the register map.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL: begin
                bus_rdata_o[B_EN]             = en;
                bus_rdata_o[B_MODE]           = mode;
                bus_rdata_o[B_PSL +: SEL_W]   = psel;
            end
            A_CNT_LO: bus_rdata_o = count[BYTE_W-1:0];
            A_CNT_HI: bus_rdata_o = shadow;
            A_PER_LO: bus_rdata_o = period[BYTE_W-1:0];
            A_PER_HI: bus_rdata_o = period[CNT_W-1:BYTE_W];
            A_FLAG:   bus_rdata_o[0] = flag;
            default:  bus_rdata_o = '0;
        endcase
    end

    always_comb irq_o = flag;

    a_r6_disable_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_lo) |=> $stable(count));
endmodule

// File: tb/tb_pm_timer.sv
module tb_pm_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic bus_wr_i = 1'b0;
    logic bus_rd_i = 1'b0;
    logic [2:0] bus_addr_i = '0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic irq_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    pm_timer dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_rd_i = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi;
        rd(3'd1, lo);
        rd(3'd2, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_i = 1'b1;
            repeat (n) @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic setup(input int psel, input int mode, input int per, input int start);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd3, per[7:0]);
        wr(3'd4, per[15:8]);
        wr(3'd2, start[15:8]);
        wr(3'd1, start[7:0]);
        wr(3'd0, {4'b0, psel[1:0], mode[0], 1'b1});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] b;
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, b); check("R1 ctrl", b, 0);
        rd16(v);     check("R1 count", v, 0);
        rd(3'd3, b); check("R1 per lo", b, 8'hFF);
        rd(3'd4, b); check("R1 per hi", b, 8'hFF);
        rd(3'd5, b); check("R1 flag", b, 0);
        check("R1 irq", irq_o, 0);

        // R5 R7 R8 sweep over prescale, mode and period
        for (int ps = 0; ps < 4; ps++) begin
            for (int md = 0; md < 2; md++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    int per, ev, ec, ef, ee;
                    per = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 6;
                    setup(ps, md, per, 0);
                    ticks(24);
                    ev = 24 >> ps;
                    if (md == 0) begin
                        ec = ev % (per + 1); ef = (ev >= per + 1) ? 1 : 0; ee = 1;
                    end else if (ev >= per + 1) begin
                        ec = 0; ef = 1; ee = 0;
                    end else begin
                        ec = ev; ef = 0; ee = 1;
                    end
                    rd16(v);     check(md ? "R8 sweep count" : "R7 R5 sweep count", v, ec);
                    rd(3'd5, b); check(md ? "R8 sweep flag" : "R7 sweep flag", b, ef);
                    rd(3'd0, b); check(md ? "R8 sweep enable" : "R7 sweep enable", b[0], ee);
                end
            end
        end

        // R2 atomic read across a carry
        setup(0, 0, 16'h4000, 16'h12FF);
        rd(3'd1, b); check("R2 low byte", b, 8'hFF);
        ticks(1);
        rd(3'd2, b); check("R2 buffered high", b, 8'h12);
        rd16(v);     check("R2 fresh read", v, 16'h1300);

        // R3 high write alone leaves counter
        wr(3'd2, 8'h55);
        rd16(v);     check("R3 high write no load", v, 16'h1300);
        wr(3'd2, 8'h21);
        wr(3'd1, 8'h07);
        rd16(v);     check("R3 low write commits", v, 16'h2107);

        // R4 high write keeps prescaler phase (divide by 4)
        setup(2, 0, 16'h4000, 16'h0010);
        ticks(2);
        wr(3'd2, 8'h00);
        ticks(2);
        rd16(v);     check("R4 phase kept", v, 16'h0011);
        // R3 low write clears the prescaler
        ticks(2);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h20);
        ticks(2);
        rd16(v);     check("R3 prescaler cleared", v, 16'h0020);
        ticks(2);
        rd16(v);     check("R3 next event", v, 16'h0021);

        // R6 disable keeps count and clears the prescaler
        ticks(2);
        wr(3'd0, 8'h08);
        rd16(v);     check("R6 count kept", v, 16'h0021);
        ticks(5);
        rd16(v);     check("R5 ticks ignored when disabled", v, 16'h0021);
        wr(3'd0, 8'h09);
        ticks(2);
        rd16(v);     check("R6 prescaler reset", v, 16'h0021);
        ticks(2);
        rd16(v);     check("R6 counting resumes", v, 16'h0022);

        // R7 rollover in continuous mode
        setup(0, 0, 16'h0010, 16'hFFFE);
        ticks(1);
        rd16(v);     check("R7 at top", v, 16'hFFFF);
        check("R7 no flag yet", irq_o, 0);
        ticks(1);
        rd16(v);     check("R7 wrap count", v, 0);
        check("R7 wrap flag", irq_o, 1);

        // R8 single-shot top wrap without flag
        setup(0, 1, 16'h0010, 16'hFFFF);
        ticks(1);
        rd16(v);     check("R8 wrap count", v, 0);
        check("R8 wrap no flag", irq_o, 0);
        rd(3'd0, b); check("R8 still enabled", b[0], 1);

        // R10 period change while running
        setup(0, 0, 16'h0040, 0);
        ticks(3);
        wr(3'd3, 8'h04);
        wr(3'd4, 8'h00);
        ticks(2);
        rd16(v);     check("R10 new period count", v, 0);
        check("R10 new period flag", irq_o, 1);

        // R9 set wins over same-cycle clear
        setup(0, 0, 16'h0002, 0);
        ticks(2);
        @(negedge clk);
        tick_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 3'd5; bus_wdata_i = 8'h00;
        @(negedge clk);
        tick_i = 1'b0; bus_wr_i = 1'b0;
        rd(3'd5, b); check("R9 set wins", b, 1);
        wr(3'd5, 8'h01);
        rd(3'd5, b); check("R9 write one no effect", b, 1);
        wr(3'd5, 8'h00);
        rd(3'd5, b); check("R9 clear", b, 0);
        wr(3'd5, 8'h01);
        rd(3'd5, b); check("R9 write one no set", b, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule